// File: doc/BRIEF.md
# Line Driver Fault Flag and Output Control

This block lies between the status detectors of a serial-video cable driver and its output stage. It receives three raw status flags: a termination fault on the true output, a termination fault on the complement output, and an input signal-present flag. It also receives the output-enable pin, the edge-rate pin and a set of configuration fields. Its outputs are a status byte, an active-low fault flag for an open-drain pad, the effective edge-rate select, the output power-down decision and the action taken on loss of signal, which is either a mute or a small added offset.

Each fault source has its own mask bit and its own polarity bit. The pins override the register bits in one direction only: a high rate pin forces SD and a low enable pin forces power-down. Loss of signal can be made part of the power-down decision. Every raw input passes through a two-flop synchronizer. The termination-fault flags are held at zero while the output is powered down, and for a programmable number of cycles after power-up, so that the detectors can settle.

Top module: `line_fault_ctrl`

## Requirements
- R1: A change on any raw input (`tfPRaw`, `tfNRaw`, `sigRaw`, `enablePin`, `ratePin`) is not visible on the outputs after one rising clock edge, and is visible after the second rising edge.
- R2: `statusReg` bit 0 is signal present (1 = signal detected), bit 1 is the true-output termination fault, bit 2 is the complement-output termination fault, and bits 7:3 read 0.
- R3: `faultN` is 0 when at least one unmasked source is in its active state, and 1 otherwise. The mask bits are `maskBits[0]` for signal, `maskBits[1]` for the true-output fault and `maskBits[2]` for the complement-output fault, and 1 means masked.
- R4: With `polBits[i]` = 0, a termination fault is active at 1 and the signal source is active at 0 (signal lost). With `polBits[i]` = 1, each active level is inverted. The bit order matches `maskBits`.
- R5: `sdRate` is 1 whenever the synchronized rate pin is high. Otherwise it equals `rateSelReg`.
- R6: `outPowerDown` is 1 whenever the synchronized enable pin is low. With the pin high, it follows `pwrDownReg`.
- R7: With `lossPdEn` = 1 and the enable pin high, a lost signal sets `outPowerDown`. With the signal present, the decision falls back to `pwrDownReg`.
- R8: When the loss action is applied, `muteSel` = 1 gives `muteOut` = 1 and `muteSel` = 0 gives `offsetOut` = 1. With a signal present and no force bit set, both are 0.
- R9: `lossNever` = 1 stops the loss action from being applied. `lossAlways` = 1 applies it even with a signal present. When both are set, `lossNever` wins. Status bit 0 reports the true signal state in every case.
- R10: Both termination-fault status bits read 0 while `outPowerDown` is 1. After power-up they stay 0 until `settleCount` rising edges have passed with the output up, and they pass the synchronized flags from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tfPRaw | input | 1 | Raw termination fault, true output |
| tfNRaw | input | 1 | Raw termination fault, complement output |
| sigRaw | input | 1 | Raw input signal present |
| enablePin | input | 1 | Output enable pin, low forces power-down |
| ratePin | input | 1 | Edge-rate pin, high forces SD rate |
| maskBits | input | 3 | Per-source fault mask |
| polBits | input | 3 | Per-source active-level invert |
| rateSelReg | input | 1 | Register edge-rate select, 1 = SD |
| pwrDownReg | input | 1 | Register power-down, 1 = down |
| lossPdEn | input | 1 | Include signal loss in power-down |
| muteSel | input | 1 | Loss action: 1 mute, 0 offset |
| lossNever | input | 1 | Never apply the loss action |
| lossAlways | input | 1 | Always apply the loss action |
| settleCount | input | SETTLE_W | Post-power-up hold of the fault flags, in cycles |
| faultN | output | 1 | Active-low fault flag (0 = drive pad low) |
| statusReg | output | 8 | Status byte |
| sdRate | output | 1 | Effective edge rate, 1 = SD |
| outPowerDown | output | 1 | Output stage power-down |
| muteOut | output | 1 | Mute the output |
| offsetOut | output | 1 | Add an offset to the output |

## Verification
A change on a raw pin or flag reaches the outputs two rising edges after it is sampled. A configuration field acts on the outputs within the same cycle, except for the settle count, which reveals the termination flags `settleCount` edges after power-up. The bench drives every input on the falling edge and samples on a later falling edge. After a raw change it waits two rising edges, or six when a power transition has restarted the settle hold. For R1 and R10 it samples on the exact edge before and the exact edge after the change is due.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int NUM_RAW  = 5;
  localparam int IDX_TFP  = 0;
  localparam int IDX_TFN  = 1;
  localparam int IDX_SIG  = 2;
  localparam int IDX_EN   = 3;
  localparam int IDX_RATE = 4;

  typedef struct packed {
    logic pwrDown;
  } ctlStrobe_t;
endpackage

// File: rtl/lfc_datapath.sv
module lfc_datapath
  import lfc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_RAW-1:0]  rawIn,
  input  logic [SETTLE_W-1:0] settleCount,
  input  ctlStrobe_t          strobe,
  output logic [NUM_RAW-1:0]  syncVec,
  output logic                tfPHeld,
  output logic                tfNHeld,
  output logic [7:0]          statusReg
);
  localparam int PAD_W = 8 - 3;

  // Synchronizer chain for each raw input.
  for (genvar i = 0; i < NUM_RAW; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[i]};
    end
    assign syncVec[i] = chain[SYNC_STAGES-1];
  end

  // Settle counter: cleared while down, counts up to settleCount once up.
  logic [SETTLE_W-1:0] settleCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       settleCnt <= '0;
    else if (strobe.pwrDown)         settleCnt <= '0;
    else if (settleCnt < settleCount) settleCnt <= settleCnt + 1'b1;
  end

  logic tfOpen;
  assign tfOpen  = !strobe.pwrDown && (settleCnt >= settleCount);
  assign tfPHeld = syncVec[IDX_TFP] & tfOpen;
  assign tfNHeld = syncVec[IDX_TFN] & tfOpen;

  assign statusReg = {{PAD_W{1'b0}}, tfNHeld, tfPHeld, syncVec[IDX_SIG]};
endmodule

// File: rtl/lfc_control.sv
module lfc_control
  import lfc_pkg::*;
(
  input  logic [NUM_RAW-1:0] syncVec,
  input  logic               tfPHeld,
  input  logic               tfNHeld,
  input  logic [2:0]         maskBits,
  input  logic [2:0]         polBits,
  input  logic               rateSelReg,
  input  logic               pwrDownReg,
  input  logic               lossPdEn,
  input  logic               muteSel,
  input  logic               lossNever,
  input  logic               lossAlways,
  output ctlStrobe_t         strobe,
  output logic               faultN,
  output logic               sdRate,
  output logic               outPowerDown,
  output logic               muteOut,
  output logic               offsetOut
);
  logic sigOk, enHigh;
  logic [2:0] srcLevel, srcActive;
  logic lossApplied;

  assign sigOk  = syncVec[IDX_SIG];
  assign enHigh = syncVec[IDX_EN];

  // Source levels with a fault-active sense of 1: signal source is active when lost.
  assign srcLevel  = {tfNHeld, tfPHeld, !sigOk};
  assign srcActive = (srcLevel ^ polBits) & ~maskBits;
  assign faultN    = ~|srcActive;

  assign sdRate = syncVec[IDX_RATE] | rateSelReg;

  always_comb begin
    if (!enHigh)                 outPowerDown = 1'b1;
    else if (lossPdEn && !sigOk) outPowerDown = 1'b1;
    else                         outPowerDown = pwrDownReg;
  end
  assign strobe.pwrDown = outPowerDown;

  always_comb begin
    if (lossNever)       lossApplied = 1'b0;
    else if (lossAlways) lossApplied = 1'b1;
    else                 lossApplied = !sigOk;
  end
  assign muteOut   = lossApplied & muteSel;
  assign offsetOut = lossApplied & !muteSel;
endmodule

// File: rtl/line_fault_ctrl.sv
module line_fault_ctrl
  import lfc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tfPRaw,
  input  logic                tfNRaw,
  input  logic                sigRaw,
  input  logic                enablePin,
  input  logic                ratePin,
  input  logic [2:0]          maskBits,
  input  logic [2:0]          polBits,
  input  logic                rateSelReg,
  input  logic                pwrDownReg,
  input  logic                lossPdEn,
  input  logic                muteSel,
  input  logic                lossNever,
  input  logic                lossAlways,
  input  logic [SETTLE_W-1:0] settleCount,
  output logic                faultN,
  output logic [7:0]          statusReg,
  output logic                sdRate,
  output logic                outPowerDown,
  output logic                muteOut,
  output logic                offsetOut
);
  logic [NUM_RAW-1:0] rawIn, syncVec;
  logic tfPHeld, tfNHeld;
  ctlStrobe_t strobe;

  always_comb begin
    rawIn           = '0;
    rawIn[IDX_TFP]  = tfPRaw;
    rawIn[IDX_TFN]  = tfNRaw;
    rawIn[IDX_SIG]  = sigRaw;
    rawIn[IDX_EN]   = enablePin;
    rawIn[IDX_RATE] = ratePin;
  end

  lfc_datapath #(.SYNC_STAGES(SYNC_STAGES), .SETTLE_W(SETTLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .settleCount(settleCount),
    .strobe(strobe), .syncVec(syncVec), .tfPHeld(tfPHeld), .tfNHeld(tfNHeld),
    .statusReg(statusReg)
  );

  lfc_control u_ctl (
    .syncVec(syncVec), .tfPHeld(tfPHeld), .tfNHeld(tfNHeld),
    .maskBits(maskBits), .polBits(polBits), .rateSelReg(rateSelReg),
    .pwrDownReg(pwrDownReg), .lossPdEn(lossPdEn), .muteSel(muteSel),
    .lossNever(lossNever), .lossAlways(lossAlways), .strobe(strobe),
    .faultN(faultN), .sdRate(sdRate), .outPowerDown(outPowerDown),
    .muteOut(muteOut), .offsetOut(offsetOut)
  );
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
  parameter int SETTLE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                enablePin,
  input logic                ratePin,
  input logic [2:0]          maskBits,
  input logic                lossNever,
  input logic [SETTLE_W-1:0] settleCount,
  input logic                faultN,
  input logic [7:0]          statusReg,
  input logic                sdRate,
  input logic                outPowerDown,
  input logic                muteOut,
  input logic                offsetOut
);
  logic [1:0] upCnt;
  logic warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 1'b1;
  end
  assign warm = (upCnt == 2'd3);

  p_all_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == 3'b111) |-> faultN);
  p_rate_pin_r5: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(ratePin, 2)) |-> sdRate);
  p_enable_pin_r6: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !$past(enablePin, 2)) |-> outPowerDown);
  p_action_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(muteOut && offsetOut));
  p_never_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    lossNever |-> (!muteOut && !offsetOut));
  p_down_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    outPowerDown |-> (statusReg[2:1] == 2'b00));
  p_settle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $fell(outPowerDown) && settleCount != '0) |-> (statusReg[2:1] == 2'b00));
endmodule

bind line_fault_ctrl lfc_checker #(.SETTLE_W(SETTLE_W)) u_chk (.*);

// File: tb/line_fault_ctrl_tb.sv
module line_fault_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tfPRaw = 0, tfNRaw = 0, sigRaw = 1, enablePin = 1, ratePin = 0;
  logic [2:0] maskBits = 0, polBits = 0;
  logic rateSelReg = 0, pwrDownReg = 0, lossPdEn = 0, muteSel = 0;
  logic lossNever = 0, lossAlways = 0;
  logic [7:0] settleCount = 8'd4;
  logic faultN, sdRate, outPowerDown, muteOut, offsetOut;
  logic [7:0] statusReg;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  line_fault_ctrl u_dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected fault flag from R3/R4: srcs {tfN, tfP, sigLost}.
  function automatic logic expFault(logic tfn, logic tfp, logic sig);
    logic [2:0] act;
    act = ({tfn, tfp, !sig} ^ polBits) & ~maskBits;
    return ~|act;
  endfunction

  task automatic waitLong(); repeat (6) @(negedge clk); endtask

  task automatic t_reset();
    chk("R2 reset status", statusReg, 8'h00);
    chk("R6 reset powered down", {7'd0, outPowerDown}, 8'd1);
  endtask

  task automatic t_latency();
    sigRaw = 1; waitLong();
    sigRaw = 0;
    @(negedge clk);
    chk("R1 one edge not yet", statusReg[0], 1'b1);
    @(negedge clk);
    chk("R1 two edges visible", statusReg[0], 1'b0);
    sigRaw = 1; waitLong();
  endtask

  task automatic t_status();
    tfPRaw = 1; tfNRaw = 0; waitLong();
    chk("R2 tfP bit1", statusReg, 8'h03);
    tfPRaw = 0; tfNRaw = 1; sigRaw = 0; waitLong();
    chk("R2 tfN bit2 sig lost", statusReg, 8'h04);
    tfNRaw = 0; sigRaw = 1; waitLong();
  endtask

  task automatic t_mask();
    tfPRaw = 1; waitLong();
    chk("R3 unmasked tfP", faultN, expFault(0, 1, 1));
    chk("R3 unmasked tfP low", faultN, 1'b0);
    maskBits = 3'b010; #1;
    chk("R3 tfP masked", faultN, 1'b1);
    tfPRaw = 0; sigRaw = 0; maskBits = 3'b000; waitLong();
    chk("R3 sig lost", faultN, 1'b0);
    maskBits = 3'b001; #1;
    chk("R3 sig masked", faultN, 1'b1);
    maskBits = 0; sigRaw = 1; waitLong();
    chk("R3 quiet", faultN, 1'b1);
  endtask

  task automatic t_polarity();
    polBits = 3'b100; #1;
    chk("R4 tfN inverted active at 0", faultN, 1'b0);
    tfNRaw = 1; waitLong();
    chk("R4 tfN inverted quiet at 1", faultN, expFault(1, 0, 1));
    polBits = 3'b001; tfNRaw = 0; waitLong();
    chk("R4 sig inverted active present", faultN, 1'b0);
    polBits = 0; #1;
  endtask

  task automatic t_rate();
    ratePin = 0; rateSelReg = 0; #1;
    chk("R5 HD", sdRate, 1'b0);
    rateSelReg = 1; #1;
    chk("R5 reg SD", sdRate, 1'b1);
    rateSelReg = 0; ratePin = 1; waitLong();
    chk("R5 pin SD", sdRate, 1'b1);
    ratePin = 0; waitLong();
  endtask

  task automatic t_pd();
    chk("R6 up", outPowerDown, 1'b0);
    pwrDownReg = 1; #1;
    chk("R6 reg down", outPowerDown, 1'b1);
    pwrDownReg = 0; enablePin = 0; waitLong();
    chk("R6 pin down", outPowerDown, 1'b1);
    enablePin = 1; waitLong();
    chk("R6 pin up", outPowerDown, 1'b0);
  endtask

  task automatic t_losspd();
    lossPdEn = 1; sigRaw = 0; waitLong();
    chk("R7 loss powers down", outPowerDown, 1'b1);
    sigRaw = 1; waitLong();
    chk("R7 present falls back", outPowerDown, 1'b0);
    lossPdEn = 0; waitLong();
  endtask

  task automatic t_lossact();
    chk("R8 present none", {muteOut, offsetOut}, 2'b00);
    sigRaw = 0; muteSel = 0; waitLong();
    chk("R8 offset", {muteOut, offsetOut}, 2'b01);
    muteSel = 1; #1;
    chk("R8 mute", {muteOut, offsetOut}, 2'b10);
  endtask

  task automatic t_force();
    lossNever = 1; #1;
    chk("R9 never", {muteOut, offsetOut}, 2'b00);
    chk("R9 status true", statusReg[0], 1'b0);
    lossAlways = 1; #1;
    chk("R9 both never wins", {muteOut, offsetOut}, 2'b00);
    lossNever = 0; sigRaw = 1; waitLong();
    chk("R9 always applied", {muteOut, offsetOut}, 2'b10);
    chk("R9 status true present", statusReg[0], 1'b1);
    lossAlways = 0; muteSel = 0; #1;
  endtask

  task automatic t_settle();
    tfPRaw = 1; waitLong();
    chk("R10 visible when up", statusReg[1], 1'b1);
    pwrDownReg = 1; #1;
    chk("R10 held while down", statusReg[1], 1'b0);
    @(negedge clk);
    pwrDownReg = 0;
    repeat (3) @(negedge clk);
    chk("R10 held before settle", statusReg[1], 1'b0);
    @(negedge clk);
    chk("R10 released after settle", statusReg[1], 1'b1);
    tfPRaw = 0; waitLong();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    waitLong();
    t_latency();
    t_status();
    t_mask();
    t_polarity();
    t_rate();
    t_pd();
    t_losspd();
    t_lossact();
    t_force();
    t_settle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule